// File: doc/BRIEF.md
# Transfer Ring Fetch Engine

This block is the device-side consumer for one unidirectional channel whose work items sit in a circular ring of descriptors in host memory. Software on the device side loads a channel context: ring base address, ring length in descriptors, read pointer, write pointer and the channel direction. Pointers are descriptor-granular addresses. The host then announces new work by writing its updated write pointer through a doorbell. The engine judges each doorbell and keeps the ones that are consistent with the ring.

While the ring holds work, the engine fetches the descriptor at its read pointer through a single-outstanding memory read request and response interface. It offers the returned word to a downstream consumer with a valid/ready handshake. It moves the read pointer forward only when the consumer takes the descriptor. The ring follows the one-slot-empty convention. Equal pointers mean there is no work. A ring of length L holds at most L-1 pending descriptors.

A doorbell that would shrink the pending work, or that points outside the ring, is discarded and reported on a one-cycle error strobe. A doorbell that lands while a fetch is under way updates the cached write pointer at once and is never dropped.

Top module: `ring_xfer_consumer`

## Requirements
- R1: After reset, rd_req_valid, desc_valid and db_err are low, and rp_out and wp_out read zero.
- R2: No memory read is requested while rp_out equals wp_out (empty ring) or before the first context load. A doorbell before the first load is rejected.
- R3: A doorbell is accepted when two conditions hold. First, its pointer lies in [base, base+len). Second, its occupancy ((ptr - rp) mod len, with both offsets taken from base) is not smaller than the occupancy of the current write pointer. On acceptance, wp_out equals the doorbell pointer on the next cycle and db_err stays low.
- R4: rp_out moves by one descriptor on each cycle where desc_valid and desc_ready are both high. It moves from base+len-1 back to base. On any other cycle it holds.
- R5: rd_req_addr equals rp_out. Once a read request has been accepted, no further request is raised until that descriptor has been handed downstream. An unaccepted request holds its address.
- R6: desc_data equals the response word returned for the address in rp_out, and desc_dir equals the loaded direction. Both hold steady while desc_valid is high and desc_ready is low.
- R7: A rejected doorbell raises db_err for exactly the following cycle and leaves wp_out unchanged. Without a doorbell, db_err stays low.
- R8: A doorbell in the same cycle as a descriptor handoff is judged against the read pointer before the advance. Both effects land on the next cycle.
- R9: ctx_load replaces base, length, both pointers and direction on the next cycle and abandons any fetch in progress. A doorbell in that same cycle is rejected with db_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_load | input | 1 | Load the channel context in this cycle |
| ctx_base | input | AW | Ring base address |
| ctx_len | input | LW | Ring length in descriptors (at least 2) |
| ctx_rp | input | AW | Initial read pointer |
| ctx_wp | input | AW | Initial write pointer |
| ctx_dir | input | 1 | Channel direction, 1 = host to device |
| db_valid | input | 1 | Doorbell strobe |
| db_wp | input | AW | Write pointer carried by the doorbell |
| rd_req_valid | output | 1 | Descriptor read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | AW | Address of the descriptor to read |
| rd_rsp_valid | input | 1 | Read response strobe |
| rd_rsp_data | input | DW | Read response word |
| desc_valid | output | 1 | Descriptor offered downstream |
| desc_ready | input | 1 | Downstream takes the descriptor |
| desc_data | output | DW | Descriptor word |
| desc_dir | output | 1 | Direction of the channel the descriptor belongs to |
| db_err | output | 1 | One-cycle strobe for a rejected doorbell |
| rp_out | output | AW | Current read pointer |
| wp_out | output | AW | Cached write pointer |

## Verification
The two functions that can coincide are doorbell acceptance and read-pointer advance. In one cycle the consumer can take a descriptor while the host rings with a new write pointer. The bench provokes this by waiting until a descriptor is on offer, then forcing desc_ready high and ringing with a legal pointer in that same cycle. Random traffic produces the same overlap by chance. The bench model judges every doorbell against the read pointer as it stood before that edge, then expects rp_out advanced and wp_out replaced on the next cycle, with no error strobe.

// File: rtl/ring_cons_pkg.sv
package ring_cons_pkg;
   // fetch sequencer states
   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_REQ   = 2'd1,
      FS_WAIT  = 2'd2,
      FS_OFFER = 2'd3
   } fetch_state_e;
endpackage

// File: rtl/ring_occ.sv
// Occupancy of a pointer relative to the read pointer, plus a ring range test.
module ring_occ #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] len_i,
   input  logic [AW-1:0] rp_i,
   input  logic [AW-1:0] ptr_i,
   output logic [AW-1:0] occ_o,
   output logic          in_ring_o
);
   logic [AW-1:0] off_p;
   logic [AW-1:0] off_r;

   always_comb begin
      off_p     = ptr_i - base_i;
      off_r     = rp_i - base_i;
      in_ring_o = (ptr_i >= base_i) && (off_p < len_i);
      if (off_p >= off_r) occ_o = off_p - off_r;
      else                occ_o = off_p + len_i - off_r;
   end
endmodule

// File: rtl/ring_adv.sv
// Next descriptor address with wrap back to the base.
module ring_adv #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] len_i,
   input  logic [AW-1:0] ptr_i,
   output logic [AW-1:0] nxt_o
);
   logic [AW-1:0] inc;
   logic [AW-1:0] lim;

   always_comb begin
      inc   = ptr_i + AW'(1);
      lim   = base_i + len_i;
      nxt_o = (inc == lim) ? base_i : inc;
   end
endmodule

// File: rtl/ring_db_judge.sv
// Decides whether a doorbell pointer is consistent with the ring.
module ring_db_judge #(
   parameter int AW = 16
) (
   input  logic          db_valid_i,
   input  logic          ctx_ok_i,
   input  logic          ctx_load_i,
   input  logic          in_ring_i,
   input  logic [AW-1:0] occ_new_i,
   input  logic [AW-1:0] occ_cur_i,
   output logic          take_o,
   output logic          drop_o
);
   always_comb begin
      take_o = db_valid_i && !ctx_load_i && ctx_ok_i && in_ring_i &&
               (occ_new_i >= occ_cur_i);
      drop_o = db_valid_i && !take_o;
   end
endmodule

// File: rtl/ring_fetch_fsm.sv
// One-at-a-time descriptor fetch and downstream offer.
module ring_fetch_fsm
   import ring_cons_pkg::*;
#(
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort_i,
   input  logic          work_i,
   input  logic          req_ready_i,
   input  logic          rsp_valid_i,
   input  logic [DW-1:0] rsp_data_i,
   input  logic          desc_ready_i,
   output logic          req_valid_o,
   output logic          desc_valid_o,
   output logic [DW-1:0] desc_data_o,
   output logic          adv_o
);
   fetch_state_e  st_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= FS_IDLE;
         data_q <= '0;
      end else if (abort_i) begin
         st_q <= FS_IDLE;
      end else begin
         case (st_q)
            FS_IDLE:  if (work_i) st_q <= FS_REQ;
            FS_REQ:   if (req_ready_i) st_q <= FS_WAIT;
            FS_WAIT:  if (rsp_valid_i) begin
                         data_q <= rsp_data_i;
                         st_q   <= FS_OFFER;
                      end
            FS_OFFER: if (desc_ready_i) st_q <= FS_IDLE;
            default:  st_q <= FS_IDLE;
         endcase
      end
   end

   assign req_valid_o  = (st_q == FS_REQ);
   assign desc_valid_o = (st_q == FS_OFFER);
   assign desc_data_o  = data_q;
   assign adv_o        = (st_q == FS_OFFER) && desc_ready_i;
endmodule

// File: rtl/ring_xfer_consumer.sv
// Doorbell-driven consumer of one host-resident descriptor ring.
module ring_xfer_consumer #(
   parameter int AW = 16,
   parameter int LW = 8,
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctx_load,
   input  logic [AW-1:0] ctx_base,
   input  logic [LW-1:0] ctx_len,
   input  logic [AW-1:0] ctx_rp,
   input  logic [AW-1:0] ctx_wp,
   input  logic          ctx_dir,
   input  logic          db_valid,
   input  logic [AW-1:0] db_wp,
   output logic          rd_req_valid,
   input  logic          rd_req_ready,
   output logic [AW-1:0] rd_req_addr,
   input  logic          rd_rsp_valid,
   input  logic [DW-1:0] rd_rsp_data,
   output logic          desc_valid,
   input  logic          desc_ready,
   output logic [DW-1:0] desc_data,
   output logic          desc_dir,
   output logic          db_err,
   output logic [AW-1:0] rp_out,
   output logic [AW-1:0] wp_out
);
   localparam int NOCC = 2;   // occupancy units: cached wp, doorbell wp
   localparam int PADW = AW - LW;

   if (LW < 2)   begin : g_bad_lw  $error("LW must be at least 2"); end
   if (LW >= AW) begin : g_bad_aw  $error("AW must exceed LW"); end
   if (DW < 1)   begin : g_bad_dw  $error("DW must be positive"); end

   logic [AW-1:0] base_q, rp_q, wp_q;
   logic [LW-1:0] len_q;
   logic          dir_q, ok_q, err_q;
   logic [AW-1:0] len_x;
   logic [AW-1:0] rp_nxt;
   logic [AW-1:0] occ_ptr [NOCC];
   logic [AW-1:0] occ_val [NOCC];
   logic          in_ring [NOCC];
   logic          db_take, db_drop, work, adv;

   assign len_x      = {{PADW{1'b0}}, len_q};
   assign occ_ptr[0] = wp_q;
   assign occ_ptr[1] = db_wp;

   for (genvar g = 0; g < NOCC; g++) begin : g_occ
      ring_occ #(.AW(AW)) u_occ (
         .base_i   (base_q),
         .len_i    (len_x),
         .rp_i     (rp_q),
         .ptr_i    (occ_ptr[g]),
         .occ_o    (occ_val[g]),
         .in_ring_o(in_ring[g])
      );
   end

   ring_adv #(.AW(AW)) u_adv (
      .base_i(base_q),
      .len_i (len_x),
      .ptr_i (rp_q),
      .nxt_o (rp_nxt)
   );

   ring_db_judge #(.AW(AW)) u_judge (
      .db_valid_i(db_valid),
      .ctx_ok_i  (ok_q),
      .ctx_load_i(ctx_load),
      .in_ring_i (in_ring[1]),
      .occ_new_i (occ_val[1]),
      .occ_cur_i (occ_val[0]),
      .take_o    (db_take),
      .drop_o    (db_drop)
   );

   assign work = ok_q && in_ring[0] && (occ_val[0] != '0);

   ring_fetch_fsm #(.DW(DW)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .abort_i     (ctx_load),
      .work_i      (work),
      .req_ready_i (rd_req_ready),
      .rsp_valid_i (rd_rsp_valid),
      .rsp_data_i  (rd_rsp_data),
      .desc_ready_i(desc_ready),
      .req_valid_o (rd_req_valid),
      .desc_valid_o(desc_valid),
      .desc_data_o (desc_data),
      .adv_o       (adv)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= '0;
         rp_q   <= '0;
         wp_q   <= '0;
         dir_q  <= 1'b0;
         ok_q   <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         err_q <= db_drop;
         if (ctx_load) begin
            base_q <= ctx_base;
            len_q  <= ctx_len;
            rp_q   <= ctx_rp;
            wp_q   <= ctx_wp;
            dir_q  <= ctx_dir;
            ok_q   <= 1'b1;
         end else begin
            if (adv)     rp_q <= rp_nxt;
            if (db_take) wp_q <= db_wp;
         end
      end
   end

   assign rd_req_addr = rp_q;
   assign desc_dir    = dir_q;
   assign db_err      = err_q;
   assign rp_out      = rp_q;
   assign wp_out      = wp_q;
endmodule

// File: rtl/ring_cons_chk.sv
// Protocol checker bound to ring_xfer_consumer.
module ring_cons_chk #(
   parameter int AW = 16,
   parameter int DW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ctx_load,
   input logic          rd_req_valid,
   input logic          rd_req_ready,
   input logic [AW-1:0] rd_req_addr,
   input logic          desc_valid,
   input logic          desc_ready,
   input logic [DW-1:0] desc_data,
   input logic          db_err,
   input logic [AW-1:0] rp_out,
   input logic [AW-1:0] wp_out
);
   logic outst_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                           outst_q <= 1'b0;
      else if (ctx_load)                    outst_q <= 1'b0;
      else if (desc_valid && desc_ready)    outst_q <= 1'b0;
      else if (rd_req_valid && rd_req_ready) outst_q <= 1'b1;
   end

   // R2
   empty_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> (rp_out != wp_out));

   // R5
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      outst_q |-> !rd_req_valid);

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid && !rd_req_ready && !ctx_load |=> rd_req_valid && $stable(rd_req_addr));

   // R4
   rp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(desc_valid && desc_ready) && !ctx_load |=> $stable(rp_out));

   // R4
   rp_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && desc_ready && !ctx_load |=> rp_out != $past(rp_out));

   // R6
   desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && !desc_ready && !ctx_load |=> desc_valid && $stable(desc_data));

   // R7
   reject_keeps_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      db_err && !$past(ctx_load) |-> $stable(wp_out));
endmodule

bind ring_xfer_consumer ring_cons_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctx_load    (ctx_load),
   .rd_req_valid(rd_req_valid),
   .rd_req_ready(rd_req_ready),
   .rd_req_addr (rd_req_addr),
   .desc_valid  (desc_valid),
   .desc_ready  (desc_ready),
   .desc_data   (desc_data),
   .db_err      (db_err),
   .rp_out      (rp_out),
   .wp_out      (wp_out)
);

// File: tb/tb_ring_xfer_consumer.sv
module tb_ring_xfer_consumer;
   localparam int AW = 16;
   localparam int LW = 8;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ctx_load;
   logic [AW-1:0] ctx_base, ctx_rp, ctx_wp;
   logic [LW-1:0] ctx_len;
   logic          ctx_dir;
   logic          db_valid;
   logic [AW-1:0] db_wp;
   logic          rd_req_valid, rd_req_ready;
   logic [AW-1:0] rd_req_addr;
   logic          rd_rsp_valid;
   logic [DW-1:0] rd_rsp_data;
   logic          desc_valid, desc_ready, desc_dir, db_err;
   logic [DW-1:0] desc_data;
   logic [AW-1:0] rp_out, wp_out;

   always #10 clk = ~clk;   // 50 MHz

   ring_xfer_consumer #(.AW(AW), .LW(LW), .DW(DW)) dut (.*);

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   // bench model
   logic [AW-1:0] exp_base = '0, exp_rp = '0, exp_wp = '0;
   int            exp_len = 0;
   bit            exp_dir = 1'b0, ok_m = 1'b0;
   bit            p_fire = 1'b0, p_db = 1'b0, p_bad = 1'b0, b_outst = 1'b0;
   logic [AW-1:0] p_w = '0;
   bit            mem_pend = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   int            mem_dly = 0;

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", rq, act, expv);
      end
   endtask

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return {a, ~a, a ^ 16'h5a5a, a + 16'h1234};
   endfunction

   function automatic int b_occ(input logic [AW-1:0] w, input logic [AW-1:0] r);
      int ow = int'(w) - int'(exp_base);
      int orr = int'(r) - int'(exp_base);
      return (ow - orr + exp_len) % exp_len;
   endfunction

   function automatic bit b_inr(input logic [AW-1:0] w);
      return int'(w) >= int'(exp_base) && int'(w) < int'(exp_base) + exp_len;
   endfunction

   function automatic logic [AW-1:0] b_next(input logic [AW-1:0] p);
      if (int'(p) + 1 == int'(exp_base) + exp_len) return exp_base;
      return p + 16'd1;
   endfunction

   function automatic logic [AW-1:0] pick(input bit good);
      int cur  = b_occ(exp_wp, exp_rp);
      int roff = int'(exp_rp) - int'(exp_base);
      int o;
      if (good) begin
         o = cur + int'($urandom % 32'(exp_len - cur));
         return AW'(int'(exp_base) + (roff + o) % exp_len);
      end
      if (cur > 0 && ($urandom % 2) == 0) begin
         o = int'($urandom % 32'(cur));
         return AW'(int'(exp_base) + (roff + o) % exp_len);
      end
      return AW'(int'(exp_base) + exp_len + int'($urandom % 16));
   endfunction

   // judge the previous edge's results
   task automatic settle();
      if (p_fire) begin
         exp_rp  = b_next(exp_rp);
         b_outst = 1'b0;
      end
      if (p_db) begin
         if (p_bad) chk(db_err == 1'b1, "R7 rejected doorbell flags error", 64'(db_err), 64'd1);
         else begin
            chk(db_err == 1'b0, "R3 accepted doorbell without error", 64'(db_err), 64'd0);
            exp_wp = p_w;
         end
      end else begin
         chk(db_err == 1'b0, "R7 no error without doorbell", 64'(db_err), 64'd0);
      end
      chk(wp_out == exp_wp, "R3 cached write pointer", 64'(wp_out), 64'(exp_wp));
      chk(rp_out == exp_rp, "R4 read pointer", 64'(rp_out), 64'(exp_rp));
      if (rd_req_valid)
         chk(ok_m && exp_rp != exp_wp, "R2 fetch only with work", 64'(rd_req_valid), 64'd0);
      p_fire = 1'b0;
      p_db   = 1'b0;
   endtask

   task automatic step(input bit do_db, input logic [AW-1:0] w, input bit force_rdy);
      settle();
      ctx_load     = 1'b0;
      rd_rsp_valid = 1'b0;
      if (mem_pend) begin
         if (mem_dly == 0) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = pat(mem_addr);
            mem_pend     = 1'b0;
         end else mem_dly--;
      end
      rd_req_ready = ($urandom % 3) != 0;
      if (rd_req_valid && rd_req_ready) begin
         chk(rd_req_addr == exp_rp, "R5 fetch address", 64'(rd_req_addr), 64'(exp_rp));
         chk(!b_outst, "R5 single outstanding read", 64'(b_outst), 64'd0);
         b_outst  = 1'b1;
         mem_pend = 1'b1;
         mem_addr = rd_req_addr;
         mem_dly  = int'($urandom % 4);
      end
      desc_ready = force_rdy | (($urandom % 2) == 0);
      p_fire = desc_valid && desc_ready;
      if (p_fire) begin
         chk(desc_data == pat(exp_rp), "R6 descriptor word", desc_data, pat(exp_rp));
         chk(desc_dir == exp_dir, "R6 descriptor direction", 64'(desc_dir), 64'(exp_dir));
      end
      db_valid = do_db;
      db_wp    = w;
      p_db     = do_db;
      p_w      = w;
      p_bad    = !ok_m || !b_inr(w) || (b_occ(w, exp_rp) < b_occ(exp_wp, exp_rp));
      @(negedge clk);
   endtask

   task automatic load(input logic [AW-1:0] b, input int l, input logic [AW-1:0] r,
                       input logic [AW-1:0] wv, input bit d, input bit do_db, input logic [AW-1:0] w);
      settle();
      ctx_load = 1'b1;
      ctx_base = b; ctx_len = LW'(l); ctx_rp = r; ctx_wp = wv; ctx_dir = d;
      rd_rsp_valid = 1'b0; rd_req_ready = 1'b0; desc_ready = 1'b0;
      db_valid = do_db; db_wp = w;
      p_fire = 1'b0; p_db = do_db; p_bad = 1'b1; p_w = w;
      exp_base = b; exp_len = l; exp_rp = r; exp_wp = wv; exp_dir = d; ok_m = 1'b1;
      b_outst = 1'b0; mem_pend = 1'b0;
      @(negedge clk);
   endtask

   task automatic drain();
      for (int i = 0; i < 600; i++) begin
         if (exp_rp == exp_wp && !p_fire && !p_db && !mem_pend && !desc_valid && !rd_req_valid) break;
         step(1'b0, '0, 1'b0);
      end
   endtask

   initial begin
      rst_n = 1'b0; ctx_load = 1'b0; ctx_base = '0; ctx_len = '0; ctx_rp = '0; ctx_wp = '0;
      ctx_dir = 1'b0; db_valid = 1'b0; db_wp = '0; rd_req_ready = 1'b0;
      rd_rsp_valid = 1'b0; rd_rsp_data = '0; desc_ready = 1'b0;
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!rd_req_valid && !desc_valid, "R1 idle after reset", 64'({rd_req_valid, desc_valid}), 64'd0);
      chk(db_err == 1'b0, "R1 no error after reset", 64'(db_err), 64'd0);
      chk(rp_out == '0 && wp_out == '0, "R1 pointers zero", 64'({rp_out, wp_out}), 64'd0);

      // R2 doorbell before any load is rejected, nothing fetched
      step(1'b1, 16'h0004, 1'b0);
      repeat (5) step(1'b0, '0, 1'b0);

      // small ring, fill to len-1 through the wrap
      load(16'h0100, 5, 16'h0103, 16'h0103, 1'b1, 1'b0, '0);
      step(1'b1, 16'h0102, 1'b0);
      drain();
      chk(rp_out == 16'h0102, "R4 wrap back to base", 64'(rp_out), 64'h0102);
      step(1'b1, 16'h0105, 1'b0);   // R7 outside ring
      step(1'b1, 16'h0104, 1'b0);   // legal, occupancy 2
      step(1'b1, 16'h0103, 1'b0);   // R7 shrinks pending work
      drain();

      repeat (3000) step(($urandom % 4) == 0, pick(($urandom % 5) != 0), 1'b0);
      drain();

      // R8 doorbell coinciding with a handoff
      repeat (12) begin
         logic [AW-1:0] pre_rp, w;
         step(1'b1, pick(1'b1), 1'b0);
         for (int i = 0; i < 40; i++) if (!desc_valid) step(1'b0, '0, 1'b0);
         if (desc_valid) begin
            pre_rp = exp_rp;
            w = pick(1'b1);
            step(1'b1, w, 1'b1);
            chk(rp_out == b_next(pre_rp) && wp_out == w, "R8 doorbell and handoff together",
                64'({rp_out, wp_out}), 64'({b_next(pre_rp), w}));
         end
      end
      drain();

      // R9 reload with a doorbell in the same cycle
      load(16'h2000, 200, 16'h20c5, 16'h2003, 1'b0, 1'b1, 16'h2010);
      chk(db_err == 1'b1 && wp_out == 16'h2003 && rp_out == 16'h20c5, "R9 reload wins over doorbell",
          64'({db_err, rp_out, wp_out}), 64'({1'b1, 16'h20c5, 16'h2003}));
      repeat (3000) step(($urandom % 4) == 0, pick(($urandom % 5) != 0), 1'b0);
      drain();
      settle();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired act=0 exp=1");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end
endmodule